// File: doc/BRIEF.md
# Debug burst access engine

This block sits on the debug side of a small 16-bit processor. It gives an external serial host read and write access to the target's memory and to its CPU register file. The host reaches the block through eight 16-bit registers. It loads a target address, a data word and an element count. It then writes an access-control word that chooses the direction, the target (memory or register file) and the width (word or byte). Setting the start bit in that same write launches the operation.

With a count of zero the engine makes one access, and the data register is both the source and the destination. With a count of N greater than zero it runs N+1 accesses back to back and steps the address after each one. In a burst, the write data arrives on a byte-wide receive handshake and the read data leaves on a byte-wide transmit handshake. Byte accesses steer the data to one lane of the 16-bit word and zero-extend on the way back. The same register page also exposes a fixed 32-bit identification value, a CPU control register that issues a run pulse, and a status register.

Top module: `dbg_burst_engine`

## Requirements
- R1: The access-control register sits at offset 4. In a write, bit 1 selects write (1) or read (0), bit 2 selects the register file (1) or memory (0), and bit 3 selects byte (1) or word (0). Bit 0 is a start strobe that launches the operation only when the engine is idle. Bit 0 always reads back as 0, so writing 0xFFFE reads back 0x000E and starts nothing.
- R2: The count register holds the number of accesses minus one. A count of 4 gives exactly five accesses.
- R3: The address register (offset 5), the data register (offset 6) and the count register (offset 7) are full 16-bit read/write registers. Any register read returns on reg_rdata one clock after reg_addr is presented.
- R4: A word memory access drives mem_be = 2'b11. Within a word memory burst the address advances by 2 after each element.
- R5: A register-file access uses address bits [RF_AW-1:0] as the register index and is always a full word, whatever bit 3 says. Within such a burst the index advances by 1 after each element.
- R6: A byte memory write drives the byte on both lanes of mem_wdata. It enables only one lane: mem_be = 2'b01 at an even address and 2'b10 at an odd address. The other byte of the word is left unchanged. Within a byte burst the address advances by 1.
- R7: A byte memory read returns the addressed byte zero-extended to 16 bits. In a burst, each element of a byte read is sent as a single transmit byte.
- R8: In a burst, each word element, whether it goes to memory or to the register file, is carried as two bytes, low byte first. This holds on both the receive and the transmit side.
- R9: Offsets 0 and 1 return the low and high halves of a fixed 32-bit identity and ignore writes. From MSB to LSB the identity packs program memory size (6 bits), data memory size (9 bits), multiplier present (1), peripheral space (7), user version (5), ASIC flag (1) and CPU version (3).
- R10: The CPU control register (offset 2) keeps only bits 6:3, so writing 0xFFFF reads back 0x0078. A write with bit 1 set raises cpu_run for the next clock, and bit 1 is not stored. The status register (offset 3) always reads 0.
- R11: busy is high from the clock after a start until the operation completes. A write element is issued only after all of its bytes have been received. tx_valid and tx_data hold steady until tx_ready accepts the byte.
- R12: After the last element the engine returns to idle, and the address register points one step past the last element accessed.
- R13: While busy is high, host writes to offsets 4 to 7 are ignored.
- R14: With a count of 0, a single write takes its value from the data register, and a single read loads the data register (zero-extended for byte memory reads). No byte is received or transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| cpu_run | output | 1 | One-clock run command pulse |
| busy | output | 1 | Access operation in progress |
| rx_valid | input | 1 | Incoming burst byte available |
| rx_data | input | 8 | Incoming burst byte |
| rx_ready | output | 1 | Engine accepts an incoming byte |
| tx_valid | output | 1 | Outgoing burst byte available |
| tx_data | output | 8 | Outgoing burst byte |
| tx_ready | input | 1 | Host accepts an outgoing byte |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 2 | Memory byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one clock after mem_en |
| rf_en | output | 1 | Register file access enable |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | RF_AW | Register index |
| rf_wdata | output | 16 | Register file write data |
| rf_rdata | input | 16 | Register file read data, one clock after rf_en |

## Verification
The hardest case to reach is a host register write that lands while a burst is still running. That write must change nothing, so the host has to catch the engine in the middle of an operation. The stimulus gets there by starting a two-element read burst and holding tx_ready low. The engine then stalls on its first outgoing byte, and in that window the bench writes the address, count and control registers. Only then does it drain the bytes. The byte-lane preservation case is reached by a byte burst over words that already hold known data, followed by a single word read.

// File: rtl/dbg_burst_pkg.sv
package dbg_burst_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_ID_LO   = 3'd0;
  localparam logic [2:0] OFF_ID_HI   = 3'd1;
  localparam logic [2:0] OFF_CPU_CTL = 3'd2;
  localparam logic [2:0] OFF_CPU_ST  = 3'd3;
  localparam logic [2:0] OFF_ACC_CTL = 3'd4;
  localparam logic [2:0] OFF_ADDR    = 3'd5;
  localparam logic [2:0] OFF_DATA    = 3'd6;
  localparam logic [2:0] OFF_CNT     = 3'd7;

  typedef struct packed {
    logic narrow;   // byte access
    logic use_rf;   // register file target
    logic wr;       // write direction
  } acc_mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_GETLO, S_GETHI, S_ISSUE, S_WAITRD, S_SENDLO, S_SENDHI, S_ADV
  } seq_state_t;
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_burst_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] ID_VALUE = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic              data_ld,
  input  logic [WORD_W-1:0] data_nxt,
  output acc_mode_t         mode,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start,
  output logic              cpu_run
);
  logic [3:0] cpu_ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      cpu_ctl_q <= '0;
      start     <= 1'b0;
      cpu_run   <= 1'b0;
    end else begin
      start   <= 1'b0;
      cpu_run <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          OFF_CPU_CTL: begin
            cpu_ctl_q <= reg_wdata[6:3];
            cpu_run   <= reg_wdata[1];
          end
          OFF_ACC_CTL: if (!busy) begin
            mode  <= reg_wdata[3:1];
            start <= reg_wdata[0];
          end
          OFF_ADDR: if (!busy) addr_q <= reg_wdata[ADDR_W-1:0];
          OFF_DATA: if (!busy) data_q <= reg_wdata;
          OFF_CNT:  if (!busy) cnt_q  <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (addr_ld) addr_q <= addr_nxt;
      if (data_ld) data_q <= data_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        OFF_ID_LO:   reg_rdata <= ID_VALUE[15:0];
        OFF_ID_HI:   reg_rdata <= ID_VALUE[31:16];
        OFF_CPU_CTL: reg_rdata <= {9'd0, cpu_ctl_q, 3'd0};
        OFF_ACC_CTL: reg_rdata <= {12'd0, mode, 1'b0};
        OFF_ADDR:    reg_rdata <= WORD_W'(addr_q);
        OFF_DATA:    reg_rdata <= data_q;
        OFF_CNT:     reg_rdata <= WORD_W'(cnt_q);
        default:     reg_rdata <= '0;
      endcase
    end
  end

  // R13
  busy_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_addr == OFF_CNT) |=> $stable(cnt_q));

  // R10
  run_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_run |-> ($past(reg_we) && $past(reg_addr) == OFF_CPU_CTL && $past(reg_wdata[1])));
endmodule

// File: rtl/dbg_lane.sv
module dbg_lane
  import dbg_burst_pkg::*;
(
  input  acc_mode_t         mode,
  input  logic              addr_lsb,
  input  logic [WORD_W-1:0] data_q,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] rd_val
);
  always_comb begin
    if (mode.narrow) begin
      mem_wdata = {data_q[BYTE_W-1:0], data_q[BYTE_W-1:0]};
      mem_be    = addr_lsb ? 2'b10 : 2'b01;
    end else begin
      mem_wdata = data_q;
      mem_be    = 2'b11;
    end
    if (mode.use_rf)      rd_val = rf_rdata;
    else if (mode.narrow) rd_val = {8'd0, addr_lsb ? mem_rdata[15:8] : mem_rdata[7:0]};
    else                  rd_val = mem_rdata;
  end
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  acc_mode_t         mode,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic [WORD_W-1:0] rd_val,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              seq_busy,
  output logic              acc,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              data_ld,
  output logic [WORD_W-1:0] data_nxt
);
  seq_state_t       state;
  logic [CNT_W-1:0] remaining;
  logic             stream;
  logic             narrow_mem;
  logic [1:0]       step;

  assign narrow_mem = mode.narrow && !mode.use_rf;
  assign step       = (mode.use_rf || mode.narrow) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      remaining <= '0;
      stream    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          remaining <= cnt_q;
          stream    <= (cnt_q != '0);
          state     <= (mode.wr && cnt_q != '0) ? S_GETLO : S_ISSUE;
        end
        S_GETLO:  if (rx_valid) state <= narrow_mem ? S_ISSUE : S_GETHI;
        S_GETHI:  if (rx_valid) state <= S_ISSUE;
        S_ISSUE:  state <= mode.wr ? S_ADV : S_WAITRD;
        S_WAITRD: state <= stream ? S_SENDLO : S_ADV;
        S_SENDLO: if (tx_ready) state <= narrow_mem ? S_ADV : S_SENDHI;
        S_SENDHI: if (tx_ready) state <= S_ADV;
        S_ADV: begin
          if (remaining == '0) state <= S_IDLE;
          else begin
            remaining <= remaining - CNT_W'(1);
            state     <= mode.wr ? S_GETLO : S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    data_ld  = 1'b0;
    data_nxt = data_q;
    case (state)
      S_GETLO:  if (rx_valid) begin data_ld = 1'b1; data_nxt = {8'd0, rx_data}; end
      S_GETHI:  if (rx_valid) begin data_ld = 1'b1; data_nxt = {rx_data, data_q[7:0]}; end
      S_WAITRD: begin data_ld = 1'b1; data_nxt = rd_val; end
      default: ;
    endcase
  end

  assign seq_busy = (state != S_IDLE);
  assign acc      = (state == S_ISSUE);
  assign addr_ld  = (state == S_ADV);
  assign addr_nxt = addr_q + ADDR_W'(step);
  assign rx_ready = (state == S_GETLO) || (state == S_GETHI);
  assign tx_valid = (state == S_SENDLO) || (state == S_SENDHI);
  assign tx_data  = (state == S_SENDHI) ? data_q[15:8] : data_q[7:0];

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11
  rx_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rx_valid) |=> rx_ready);
endmodule

// File: rtl/dbg_burst_engine.sv
module dbg_burst_engine
  import dbg_burst_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         RF_AW    = 4,
  parameter int         CNT_W    = 16,
  parameter logic [5:0] PMEM_SZ  = 6'd4,
  parameter logic [8:0] DMEM_SZ  = 9'd1,
  parameter logic       HAS_MUL  = 1'b1,
  parameter logic [6:0] PER_SZ   = 7'd1,
  parameter logic [4:0] USER_VER = 5'd3,
  parameter logic       IS_ASIC  = 1'b0,
  parameter logic [2:0] CPU_VER  = 3'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              cpu_run,
  output logic              busy,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rf_en,
  output logic              rf_we,
  output logic [RF_AW-1:0]  rf_idx,
  output logic [15:0]       rf_wdata,
  input  logic [15:0]       rf_rdata
);
  localparam logic [31:0] ID_VALUE =
    {PMEM_SZ, DMEM_SZ, HAS_MUL, PER_SZ, USER_VER, IS_ASIC, CPU_VER};

  acc_mode_t         mode;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [WORD_W-1:0] data_q, data_nxt, rd_val;
  logic [CNT_W-1:0]  cnt_q;
  logic              start, seq_busy, acc, addr_ld, data_ld;

  assign busy = seq_busy || start;

  dbg_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .busy,
    .addr_ld, .addr_nxt, .data_ld, .data_nxt,
    .mode, .addr_q, .data_q, .cnt_q, .start, .cpu_run
  );

  dbg_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk, .rst, .start, .mode, .cnt_q, .addr_q, .data_q, .rd_val,
    .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data, .tx_ready,
    .seq_busy, .acc, .addr_ld, .addr_nxt, .data_ld, .data_nxt
  );

  dbg_lane u_lane (
    .mode, .addr_lsb(addr_q[0]), .data_q, .mem_rdata, .rf_rdata,
    .mem_wdata, .mem_be, .rd_val
  );

  assign mem_en   = acc && !mode.use_rf;
  assign mem_we   = mode.wr;
  assign mem_addr = addr_q;
  assign rf_en    = acc && mode.use_rf;
  assign rf_we    = mode.wr;
  assign rf_idx   = addr_q[RF_AW-1:0];
  assign rf_wdata = data_q;

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && mode.narrow) |-> ($countones(mem_be) == 1 && mem_wdata[15:8] == mem_wdata[7:0]));
endmodule

// File: tb/dbg_burst_engine_test.sv
`timescale 1ns/1ps
module dbg_burst_engine_test;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata; logic cpu_run, busy;
  logic rx_valid = 1'b0; logic [7:0] rx_data = '0; logic rx_ready;
  logic tx_valid; logic [7:0] tx_data; logic tx_ready = 1'b0;
  logic mem_en, mem_we; logic [15:0] mem_addr; logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;
  logic rf_en, rf_we; logic [3:0] rf_idx; logic [15:0] rf_wdata, rf_rdata;

  int vecs = 0, fails = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] rf  [0:15];
  logic [15:0] exp_mem [0:1023];
  logic [15:0] exp_rf  [0:15];
  logic [33:0] mw_q[$]; logic [15:0] mr_q[$];
  logic [19:0] rw_q[$]; logic [3:0]  rr_q[$];

  always #2 clk = ~clk;

  dbg_burst_engine uut (.*);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 16'(i) ^ 16'hA5C3;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
    end else begin
      if (mem_en) begin
        if (mem_we) begin
          if (mem_be[0]) mem[mem_addr[10:1]][7:0]  <= mem_wdata[7:0];
          if (mem_be[1]) mem[mem_addr[10:1]][15:8] <= mem_wdata[15:8];
        end
        mem_rdata <= mem[mem_addr[10:1]];
      end
      if (rf_en) begin
        if (rf_we) rf[rf_idx] <= rf_wdata;
        rf_rdata <= rf[rf_idx];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison of every target access against the expected stream
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && mem_we) begin
        if (mw_q.size() == 0) chk("R2 R4 R6 unexpected mem write", {mem_addr, mem_be, mem_wdata[13:0]}, 32'hX);
        else begin
          logic [33:0] e; e = mw_q.pop_front();
          chk("R4 R6 mem write addr/be", {14'd0, mem_addr, mem_be}, {14'd0, e[33:18], e[17:16]});
          if (mem_be[0]) chk("R6 mem write low lane", {24'd0, mem_wdata[7:0]}, {24'd0, e[7:0]});
          if (mem_be[1]) chk("R6 mem write high lane", {24'd0, mem_wdata[15:8]}, {24'd0, e[15:8]});
        end
      end
      if (mem_en && !mem_we) begin
        if (mr_q.size() == 0) chk("R2 unexpected mem read", {16'd0, mem_addr}, 32'hX);
        else chk("R4 R6 mem read addr", {16'd0, mem_addr}, {16'd0, mr_q.pop_front()});
      end
      if (rf_en && rf_we) begin
        if (rw_q.size() == 0) chk("R5 unexpected rf write", {12'd0, rf_idx, rf_wdata}, 32'hX);
        else chk("R5 rf write", {12'd0, rf_idx, rf_wdata}, {12'd0, rw_q.pop_front()});
      end
      if (rf_en && !rf_we) begin
        if (rr_q.size() == 0) chk("R5 unexpected rf read", {28'd0, rf_idx}, 32'hX);
        else chk("R5 rf read idx", {28'd0, rf_idx}, {28'd0, rr_q.pop_front()});
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk); tx_ready = 1'b1;
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [15:0] v; logic [7:0] b, b2; logic [31:0] id; logic [15:0] base;
    for (int i = 0; i < 1024; i++) exp_mem[i] = 16'(i) ^ 16'hA5C3;
    for (int i = 0; i < 16; i++) exp_rf[i] = '0;
    id = (32'd4 << 26) | (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 9) | (32'd3 << 4) | (32'd0 << 3) | 32'd2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R11 reset busy", {31'd0, busy}, 0);
    chk("R11 reset handshakes", {30'd0, rx_ready, tx_valid}, 0);
    rd_reg(3'd4, v); chk("R1 reset ctl", {16'd0, v}, 0);
    rd_reg(3'd5, v); chk("R3 reset addr", {16'd0, v}, 0);
    rd_reg(3'd7, v); chk("R3 reset cnt", {16'd0, v}, 0);

    // R9 identity
    wr_reg(3'd0, 16'hFFFF); rd_reg(3'd0, v); chk("R9 id low", {16'd0, v}, {16'd0, id[15:0]});
    wr_reg(3'd1, 16'h0000); rd_reg(3'd1, v); chk("R9 id high", {16'd0, v}, {16'd0, id[31:16]});

    // R10 CPU control and status
    wr_reg(3'd2, 16'hFFFF); chk("R10 run pulse", {31'd0, cpu_run}, 1);
    @(negedge clk); chk("R10 run pulse width", {31'd0, cpu_run}, 0);
    rd_reg(3'd2, v); chk("R10 cpu ctl mask", {16'd0, v}, 32'h0078);
    wr_reg(3'd2, 16'h0002); rd_reg(3'd2, v); chk("R10 run bit not stored", {16'd0, v}, 0);
    wr_reg(3'd3, 16'hFFFF); rd_reg(3'd3, v); chk("R10 status", {16'd0, v}, 0);

    // R1 R3 register access
    wr_reg(3'd4, 16'hFFFE); chk("R1 no start without bit0", {31'd0, busy}, 0);
    rd_reg(3'd4, v); chk("R1 ctl readback", {16'd0, v}, 32'h000E);
    wr_reg(3'd4, 16'h0000);
    for (int r = 5; r < 8; r++) begin
      wr_reg(3'(r), 16'hFFFF); rd_reg(3'(r), v); chk("R3 reg ones", {16'd0, v}, 32'hFFFF);
      wr_reg(3'(r), 16'h0000); rd_reg(3'(r), v); chk("R3 reg zeros", {16'd0, v}, 0);
    end

    // R4 R8 word memory write burst
    base = 16'h0200;
    for (int k = 0; k < 5; k++) begin
      v = 16'h1234 + 16'(k) * 16'h2345;
      mw_q.push_back({base + 16'(2*k), 2'b11, v});
      exp_mem[10'((base + 16'(2*k)) >> 1)] = v;
    end
    wr_reg(3'd5, base); wr_reg(3'd7, 16'd4); wr_reg(3'd4, 16'h0003);
    chk("R11 busy after start", {31'd0, busy}, 1);
    for (int k = 0; k < 5; k++) begin
      v = 16'h1234 + 16'(k) * 16'h2345;
      send(v[7:0]); send(v[15:8]);
    end
    wait_idle();
    chk("R2 all five word writes issued", mw_q.size(), 0);
    rd_reg(3'd5, v); chk("R12 addr after word burst", {16'd0, v}, 32'h020A);

    // R4 R8 word memory read burst
    for (int k = 0; k < 5; k++) mr_q.push_back(base + 16'(2*k));
    wr_reg(3'd5, base); wr_reg(3'd4, 16'h0001);
    for (int k = 0; k < 5; k++) begin
      recv(b); recv(b2);
      chk("R8 word read stream", {16'd0, b2, b}, {16'd0, exp_mem[10'((base + 16'(2*k)) >> 1)]});
    end
    wait_idle();

    // R5 register file write then read burst
    for (int k = 0; k < 5; k++) begin
      v = 16'hCBA9 - 16'(k) * 16'h1111;
      rw_q.push_back({4'(5 + k), v}); exp_rf[5 + k] = v;
    end
    wr_reg(3'd5, 16'd5); wr_reg(3'd4, 16'h000F);  // bit 3 set: still word for register file
    for (int k = 0; k < 5; k++) begin
      v = 16'hCBA9 - 16'(k) * 16'h1111;
      send(v[7:0]); send(v[15:8]);
    end
    wait_idle();
    rd_reg(3'd5, v); chk("R5 R12 index after rf burst", {16'd0, v}, 32'd10);
    for (int k = 0; k < 5; k++) rr_q.push_back(4'(5 + k));
    wr_reg(3'd5, 16'd5); wr_reg(3'd4, 16'h0005);
    for (int k = 0; k < 5; k++) begin
      recv(b); recv(b2);
      chk("R5 rf read stream", {16'd0, b2, b}, {16'd0, exp_rf[5 + k]});
    end
    wait_idle();

    // R6 byte memory write burst
    for (int k = 0; k < 5; k++) begin
      b = 8'h91 - 8'(k) * 8'h0F;
      mw_q.push_back({base + 16'(k), (k % 2 == 1) ? 2'b10 : 2'b01, b, b});
      if (k % 2 == 1) exp_mem[10'((base + 16'(k)) >> 1)][15:8] = b;
      else            exp_mem[10'((base + 16'(k)) >> 1)][7:0]  = b;
    end
    wr_reg(3'd5, base); wr_reg(3'd4, 16'h000B);
    for (int k = 0; k < 5; k++) send(8'h91 - 8'(k) * 8'h0F);
    wait_idle();
    rd_reg(3'd5, v); chk("R6 R12 addr after byte burst", {16'd0, v}, 32'h0205);

    // R7 byte memory read burst
    for (int k = 0; k < 5; k++) mr_q.push_back(base + 16'(k));
    wr_reg(3'd5, base); wr_reg(3'd4, 16'h0009);
    for (int k = 0; k < 5; k++) begin
      recv(b);
      v = exp_mem[10'((base + 16'(k)) >> 1)];
      chk("R7 byte read stream", {24'd0, b}, {24'd0, (k % 2 == 1) ? v[15:8] : v[7:0]});
    end
    wait_idle();
    chk("R7 one byte per element", {31'd0, tx_valid}, 0);

    // R14 single accesses, R6 untouched lane via word read
    wr_reg(3'd7, 16'd0);
    mr_q.push_back(16'h0204); wr_reg(3'd5, 16'h0204); wr_reg(3'd4, 16'h0001);
    wait_idle();
    rd_reg(3'd6, v); chk("R6 R14 other lane preserved", {16'd0, v}, {16'd0, exp_mem[10'h102]});
    chk("R14 no stream on single read", {31'd0, tx_valid}, 0);
    mw_q.push_back({16'h0300, 2'b11, 16'hBEEF}); exp_mem[10'h180] = 16'hBEEF;
    wr_reg(3'd5, 16'h0300); wr_reg(3'd6, 16'hBEEF); wr_reg(3'd4, 16'h0003);
    wait_idle();
    chk("R14 single write done", mw_q.size(), 0);
    wr_reg(3'd6, 16'h0000);
    mr_q.push_back(16'h0301); wr_reg(3'd5, 16'h0301); wr_reg(3'd4, 16'h0009);
    wait_idle();
    rd_reg(3'd6, v); chk("R7 R14 single byte read zero-extended", {16'd0, v}, 32'h00BE);

    // R13 writes ignored while busy
    wr_reg(3'd7, 16'd1);
    mr_q.push_back(base); mr_q.push_back(base + 16'd2);
    wr_reg(3'd5, base); wr_reg(3'd4, 16'h0001);
    wr_reg(3'd5, 16'h1234); wr_reg(3'd7, 16'h0007); wr_reg(3'd4, 16'h000F);
    for (int k = 0; k < 2; k++) begin
      recv(b); recv(b2);
      chk("R13 stream unaffected", {16'd0, b2, b}, {16'd0, exp_mem[10'((base + 16'(2*k)) >> 1)]});
    end
    wait_idle();
    rd_reg(3'd5, v); chk("R13 R12 addr write ignored", {16'd0, v}, 32'h0204);
    rd_reg(3'd7, v); chk("R13 cnt write ignored", {16'd0, v}, 32'd1);
    rd_reg(3'd4, v); chk("R13 ctl write ignored", {16'd0, v}, 0);
    chk("R2 no leftover accesses", mr_q.size() + mw_q.size() + rr_q.size() + rw_q.size(), 0);

    for (int i = 0; i < 1024; i++)
      if (mem[i] !== exp_mem[i]) chk("R4 R6 final memory image", {16'd0, mem[i]}, {16'd0, exp_mem[i]});
    vecs++;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule